// File: doc/BRIEF.md
# Banked Sensor Channel Monitor

This block is the register front end of a multi-channel environmental monitor, three temperature channels by default. Software reaches a small byte-wide register window. A handful of global registers hold event status, two routing masks and a configuration byte. A channel selector register picks which channel the shared per-channel window addresses. Behind that window each channel keeps an enable bit, its latest reading and three limits.

Readings arrive from an external converter over a simple sample port: a valid strobe, a channel index and a signed 8-bit value. When the addressed channel is enabled, the block stores the value and compares it, as a signed number, against that channel's upper, lower and critical limits. Each violation latches a sticky status bit. Software clears a status bit by writing 1 to it. Two masks decide which latched events drive the SMI line and which drive the IRQ line.

Top module: `chanmon_top`

## Requirements
- R1: After reset, every channel is disabled and its reading is 0x00. Its limits read upper 0x35, lower 0x05 and critical 0x05. Status, both masks, the configuration byte and the selector all read 0x00, and `smi_o` and `irq_o` are low.
- R2: The selector at offset 0x09 reads back as written. It picks the channel that offsets 0x0A to 0x0E address, and each channel's registers are independent of the others.
- R3: Offset 0x0A bit 0 is the channel enable. Its other bits are not stored and read 0.
- R4: A sample is accepted only when `smp_valid` is high, `smp_chan` names an existing channel and that channel is enabled. An accepted sample appears at offset 0x0B from the next cycle. Any other sample changes neither the reading nor the status.
- R5: An accepted sample strictly above the channel's upper limit (offset 0x0C, signed) sets status bit 3*ch. A value equal to the limit does not set it.
- R6: An accepted sample strictly below the lower limit (offset 0x0D, signed) sets status bit 3*ch+1. A value equal to the limit does not set it.
- R7: An accepted sample at or above the critical limit (offset 0x0E, signed) sets status bit 3*ch+2.
- R8: Status bits 7..0 sit at offset 0x00 and bit 8 at offset 0x01 bit 0. A written 1 clears a bit and a written 0 leaves it alone. A bit set in the same cycle it is cleared stays set.
- R9: The SMI mask is at 0x02/0x03 and the IRQ mask at 0x04/0x05, with the same bit layout as status. `smi_o` is high exactly when status AND the SMI mask is nonzero, and `irq_o` follows the same rule with the IRQ mask.
- R10: With a selector value of 3 or more, offsets 0x0A to 0x0E read 0x00 and writes to them change no channel.
- R11: Offset 0x08 is a read/write byte. Offsets 0x06, 0x07 and 0x0F read 0x00 and ignore writes.
- R12: The reading at offset 0x0B is read-only, so a bus write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for the register window |
| reg_addr | input | 4 | Byte offset for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| smp_valid | input | 1 | Sample strobe from the converter |
| smp_chan | input | 2 | Channel index of the sample |
| smp_data | input | 8 | Signed sample value |
| smi_o | output | 1 | High while any SMI-routed event is latched |
| irq_o | output | 1 | High while any IRQ-routed event is latched |

## Verification
The hardest case to reach is a status bit being cleared by software in the same cycle a new violation sets it, because the bus and the sample port are normally driven independently. The stimulus has a dedicated task that raises a write-1-to-clear and an exceeding sample on the same clock edge, then reads the bit back. Signed comparison is forced by a negative reading that would trip the upper limit if it were compared unsigned. Limit-equal samples pin down the strict and inclusive edges. An out-of-range selector of 4, whose low bits alias channel 0, shows whether ignored writes leak into a real channel.

// File: rtl/chanmon_pkg.sv
package chanmon_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  typedef logic [ADDR_W-1:0] off_t;

  // global window
  localparam off_t OFF_STAT_LO = 4'h0;
  localparam off_t OFF_STAT_HI = 4'h1;
  localparam off_t OFF_SMIM_LO = 4'h2;
  localparam off_t OFF_SMIM_HI = 4'h3;
  localparam off_t OFF_IRQM_LO = 4'h4;
  localparam off_t OFF_IRQM_HI = 4'h5;
  localparam off_t OFF_GCFG    = 4'h8;
  localparam off_t OFF_BANK    = 4'h9;
  // banked per-channel window
  localparam off_t OFF_CCFG    = 4'hA;
  localparam off_t OFF_RDG     = 4'hB;
  localparam off_t OFF_LIMH    = 4'hC;
  localparam off_t OFF_LIML    = 4'hD;
  localparam off_t OFF_LIMO    = 4'hE;

  localparam logic [DATA_W-1:0] RST_LIMH = 8'h35;
  localparam logic [DATA_W-1:0] RST_LIML = 8'h05;
  localparam logic [DATA_W-1:0] RST_LIMO = 8'h05;
endpackage

// File: rtl/chanmon_chan.sv
module chanmon_chan
  import chanmon_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter logic [DW-1:0] LIMH_INIT = RST_LIMH,
  parameter logic [DW-1:0] LIML_INIT = RST_LIML,
  parameter logic [DW-1:0] LIMO_INIT = RST_LIMO
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cfg,
  input  logic          wr_limh,
  input  logic          wr_liml,
  input  logic          wr_limo,
  input  logic [DW-1:0] wdata,
  input  logic          smp_hit,
  input  logic [DW-1:0] smp_data,
  output logic          en_o,
  output logic [DW-1:0] rdg_o,
  output logic [DW-1:0] limh_o,
  output logic [DW-1:0] liml_o,
  output logic [DW-1:0] limo_o,
  output logic [2:0]    evt_o
);
  logic          en_q, en_d;
  logic [DW-1:0] rdg_q, rdg_d;
  logic [DW-1:0] limh_q, limh_d, liml_q, liml_d, limo_q, limo_d;
  logic          take;

  assign take = smp_hit & en_q;

  always_comb begin
    en_d   = wr_cfg  ? wdata[0] : en_q;
    limh_d = wr_limh ? wdata    : limh_q;
    liml_d = wr_liml ? wdata    : liml_q;
    limo_d = wr_limo ? wdata    : limo_q;
    rdg_d  = take    ? smp_data : rdg_q;
    evt_o  = 3'b000;
    if (take) begin
      evt_o[0] = $signed(smp_data) >  $signed(limh_q);
      evt_o[1] = $signed(smp_data) <  $signed(liml_q);
      evt_o[2] = $signed(smp_data) >= $signed(limo_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      rdg_q  <= '0;
      limh_q <= LIMH_INIT;
      liml_q <= LIML_INIT;
      limo_q <= LIMO_INIT;
    end else begin
      en_q   <= en_d;
      rdg_q  <= rdg_d;
      limh_q <= limh_d;
      liml_q <= liml_d;
      limo_q <= limo_d;
    end
  end

  assign en_o   = en_q;
  assign rdg_o  = rdg_q;
  assign limh_o = limh_q;
  assign liml_o = liml_q;
  assign limo_o = limo_q;

  AST_RDG_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) (smp_hit && en_o) |=> (rdg_o == $past(smp_data))); // R4
  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (smp_hit && !en_o) |=> $stable(rdg_o)); // R4
endmodule

// File: rtl/chanmon_evt.sv
module chanmon_evt
  import chanmon_pkg::*;
#(
  parameter int SW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SW-1:0]     set_i,
  input  logic [1:0]        wr_stat,
  input  logic [1:0]        wr_smim,
  input  logic [1:0]        wr_irqm,
  input  logic [DATA_W-1:0] wdata,
  output logic [SW-1:0]     stat_o,
  output logic [SW-1:0]     smim_o,
  output logic [SW-1:0]     irqm_o,
  output logic              smi_o,
  output logic              irq_o
);
  logic [SW-1:0] stat_q, stat_d, smim_q, smim_d, irqm_q, irqm_d, clr;

  for (genvar g = 0; g < SW; g++) begin : g_bit
    localparam int BY = g / DATA_W;
    localparam int BI = g % DATA_W;
    assign clr[g]    = wr_stat[BY] & wdata[BI];
    assign smim_d[g] = wr_smim[BY] ? wdata[BI] : smim_q[g];
    assign irqm_d[g] = wr_irqm[BY] ? wdata[BI] : irqm_q[g];
  end

  always_comb begin
    stat_d = (stat_q & ~clr) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      smim_q <= '0;
      irqm_q <= '0;
    end else begin
      stat_q <= stat_d;
      smim_q <= smim_d;
      irqm_q <= irqm_d;
    end
  end

  assign stat_o = stat_q;
  assign smim_o = smim_q;
  assign irqm_o = irqm_q;
  assign smi_o  = |(stat_q & smim_q);
  assign irq_o  = |(stat_q & irqm_q);

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n) ((clr & ~set_i) != '0) |=> ((stat_q & $past(clr & ~set_i)) == '0)); // R8
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n) (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i))); // R8
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n) ((stat_q & ~$past(stat_q)) != '0) |-> ($past(set_i) != '0)); // R5
endmodule

// File: rtl/chanmon_top.sv
module chanmon_top
  import chanmon_pkg::*;
#(
  parameter int NCH = 3,
  parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              smp_valid,
  input  logic [CW-1:0]     smp_chan,
  input  logic [DATA_W-1:0] smp_data,
  output logic              smi_o,
  output logic              irq_o
);
  localparam int SW = 3 * NCH;  // status bits, at most two bytes
  localparam int LW = 3 * DATA_W;
  localparam logic [DATA_W-1:0] NCH_B = DATA_W'(NCH);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  logic [DATA_W-1:0] gcfg_q, gcfg_d, bank_q, bank_d;
  logic              chan_ok;
  logic [CW-1:0]     sel;

  always_comb begin
    gcfg_d = (reg_wr && reg_addr == OFF_GCFG) ? reg_wdata : gcfg_q;
    bank_d = (reg_wr && reg_addr == OFF_BANK) ? reg_wdata : bank_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      gcfg_q <= '0;
      bank_q <= '0;
    end else begin
      gcfg_q <= gcfg_d;
      bank_q <= bank_d;
    end
  end

  assign chan_ok = bank_q < NCH_B;
  assign sel     = bank_q[CW-1:0];

  logic [NCH-1:0]    en_a;
  logic [DATA_W-1:0] rdg_a  [NCH];
  logic [DATA_W-1:0] limh_a [NCH];
  logic [DATA_W-1:0] liml_a [NCH];
  logic [DATA_W-1:0] limo_a [NCH];
  logic [SW-1:0]     set_v;
  logic [NCH*LW-1:0] lim_cat;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [CW-1:0] CIDX = CW'(c);
    logic wsel;
    assign wsel = reg_wr && chan_ok && (sel == CIDX);
    chanmon_chan #(.DW(DATA_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_ns),
      .wr_cfg   (wsel && reg_addr == OFF_CCFG),
      .wr_limh  (wsel && reg_addr == OFF_LIMH),
      .wr_liml  (wsel && reg_addr == OFF_LIML),
      .wr_limo  (wsel && reg_addr == OFF_LIMO),
      .wdata    (reg_wdata),
      .smp_hit  (smp_valid && smp_chan == CIDX),
      .smp_data (smp_data),
      .en_o     (en_a[c]),
      .rdg_o    (rdg_a[c]),
      .limh_o   (limh_a[c]),
      .liml_o   (liml_a[c]),
      .limo_o   (limo_a[c]),
      .evt_o    (set_v[3*c +: 3])
    );
    assign lim_cat[c*LW +: LW] = {limh_a[c], liml_a[c], limo_a[c]};
  end

  logic [SW-1:0] stat_v, smim_v, irqm_v;
  logic [15:0]   stat16, smim16, irqm16;

  chanmon_evt #(.SW(SW)) u_evt (
    .clk     (clk),
    .rst_n   (rst_ns),
    .set_i   (set_v),
    .wr_stat ({reg_wr && reg_addr == OFF_STAT_HI, reg_wr && reg_addr == OFF_STAT_LO}),
    .wr_smim ({reg_wr && reg_addr == OFF_SMIM_HI, reg_wr && reg_addr == OFF_SMIM_LO}),
    .wr_irqm ({reg_wr && reg_addr == OFF_IRQM_HI, reg_wr && reg_addr == OFF_IRQM_LO}),
    .wdata   (reg_wdata),
    .stat_o  (stat_v),
    .smim_o  (smim_v),
    .irqm_o  (irqm_v),
    .smi_o   (smi_o),
    .irq_o   (irq_o)
  );

  assign stat16 = 16'(stat_v);
  assign smim16 = 16'(smim_v);
  assign irqm16 = 16'(irqm_v);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_STAT_LO: reg_rdata = stat16[7:0];
      OFF_STAT_HI: reg_rdata = stat16[15:8];
      OFF_SMIM_LO: reg_rdata = smim16[7:0];
      OFF_SMIM_HI: reg_rdata = smim16[15:8];
      OFF_IRQM_LO: reg_rdata = irqm16[7:0];
      OFF_IRQM_HI: reg_rdata = irqm16[15:8];
      OFF_GCFG:    reg_rdata = gcfg_q;
      OFF_BANK:    reg_rdata = bank_q;
      OFF_CCFG:    if (chan_ok) reg_rdata = {{(DATA_W-1){1'b0}}, en_a[sel]};
      OFF_RDG:     if (chan_ok) reg_rdata = rdg_a[sel];
      OFF_LIMH:    if (chan_ok) reg_rdata = limh_a[sel];
      OFF_LIML:    if (chan_ok) reg_rdata = liml_a[sel];
      OFF_LIMO:    if (chan_ok) reg_rdata = limo_a[sel];
      default:     reg_rdata = '0;
    endcase
  end

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_ns) (reg_wr && !chan_ok) |=> ($stable(lim_cat) && $stable(en_a))); // R10
endmodule

// File: tb/chanmon_top_bench.sv
module chanmon_top_bench;
  localparam int CLK_PER = 10;

  logic       clk, rst_n, reg_wr, smp_valid, smi_o, irq_o;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, smp_data;
  logic [1:0] smp_chan;

  chanmon_top u_chanmon_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
    .smp_chan(smp_chan), .smp_data(smp_data), .smi_o(smi_o), .irq_o(irq_o)
  );

  typedef struct {
    int         kind;   // 0 read data, 1 smi pin, 2 irq pin
    logic [3:0] addr;
    logic [7:0] exp;
    string      rq;
  } item_t;

  item_t sbq[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;

  initial begin
    clk = 1'b0;
    forever #(CLK_PER/2) clk = ~clk;
  end

  // monitor: compares queued expectations a quarter period after each falling edge
  initial begin
    forever begin
      item_t      it;
      logic [7:0] act;
      @(negedge clk);
      #(CLK_PER/4);
      if (sbq.size() != 0) begin
        it  = sbq.pop_front();
        act = (it.kind == 0) ? reg_rdata : (it.kind == 1) ? {7'b0, smi_o} : {7'b0, irq_o};
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d addr=0x%0h actual=0x%02h expected=0x%02h", it.rq, it.kind, it.addr, act, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string rq);
    item_t it;
    @(negedge clk);
    reg_addr = a;
    it.kind = 0; it.addr = a; it.exp = e; it.rq = rq;
    sbq.push_back(it);
  endtask

  task automatic pin(input int k, input logic e, input string rq);
    item_t it;
    @(negedge clk);
    it.kind = k; it.addr = 4'h0; it.exp = {7'b0, e}; it.rq = rq;
    sbq.push_back(it);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic smp(input logic [1:0] ch, input logic [7:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_chan = ch; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic wr_smp(input logic [3:0] a, input logic [7:0] wd, input logic [1:0] ch, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = wd;
    smp_valid = 1'b1; smp_chan = ch; smp_data = d;
    @(negedge clk);
    reg_wr = 1'b0; smp_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1: run hung, actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 4'h0; reg_wdata = 8'h00;
    smp_valid = 1'b0; smp_chan = 2'd0; smp_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(4'h0, 8'h00, "R1"); rd(4'h1, 8'h00, "R1"); rd(4'h2, 8'h00, "R1");
    rd(4'h3, 8'h00, "R1"); rd(4'h4, 8'h00, "R1"); rd(4'h5, 8'h00, "R1");
    rd(4'h8, 8'h00, "R1"); rd(4'h9, 8'h00, "R1"); rd(4'hA, 8'h00, "R1");
    rd(4'hB, 8'h00, "R1"); rd(4'hC, 8'h35, "R1"); rd(4'hD, 8'h05, "R1");
    rd(4'hE, 8'h05, "R1"); pin(1, 1'b0, "R1"); pin(2, 1'b0, "R1");

    // R4 disabled channel ignores samples
    smp(2'd0, 8'h50);
    rd(4'hB, 8'h00, "R4"); rd(4'h0, 8'h00, "R4");

    // R3 enable bit only
    wr(4'hA, 8'hFF);
    rd(4'hA, 8'h01, "R3");

    // R4 R5 R7 accepted sample above upper and critical
    smp(2'd0, 8'h40);
    rd(4'hB, 8'h40, "R4"); rd(4'h0, 8'h05, "R5");

    // R8 write-one-to-clear
    wr(4'h0, 8'h01); rd(4'h0, 8'h04, "R8");
    wr(4'h0, 8'h00); rd(4'h0, 8'h04, "R8");
    wr(4'h0, 8'h04); rd(4'h0, 8'h00, "R8");

    // R6 signed compare: -10 is below lower, not above upper
    smp(2'd0, 8'hF6);
    rd(4'h0, 8'h02, "R6"); rd(4'hB, 8'hF6, "R4");
    wr(4'h0, 8'h02);

    // boundaries: equal to upper, equal to lower, just below critical
    smp(2'd0, 8'h35); rd(4'h0, 8'h04, "R5"); wr(4'h0, 8'h04);
    smp(2'd0, 8'h05); rd(4'h0, 8'h04, "R7"); wr(4'h0, 8'h04);
    smp(2'd0, 8'h04); rd(4'h0, 8'h02, "R6"); wr(4'h0, 8'h02);

    // R4 nonexistent channel index
    smp(2'd3, 8'h7F);
    rd(4'h0, 8'h00, "R4"); rd(4'hB, 8'h04, "R4");

    // R2 bank selection and independence
    wr(4'h9, 8'h02);
    rd(4'h9, 8'h02, "R2"); rd(4'hA, 8'h00, "R2"); rd(4'hC, 8'h35, "R2");
    wr(4'hC, 8'h10); wr(4'hE, 8'h7F); wr(4'hA, 8'h01);
    wr(4'h9, 8'h00); rd(4'hC, 8'h35, "R2");
    wr(4'h9, 8'h02); rd(4'hC, 8'h10, "R2"); rd(4'hE, 8'h7F, "R2");

    // channel 2 events, bit 8 lands in the high byte
    smp(2'd2, 8'h20);
    rd(4'h0, 8'h40, "R5"); rd(4'h1, 8'h00, "R8");
    smp(2'd2, 8'h7F);
    rd(4'h1, 8'h01, "R7"); rd(4'h0, 8'h40, "R8");
    smp(2'd1, 8'h7F);
    rd(4'h0, 8'h40, "R4"); rd(4'h1, 8'h01, "R4");

    // R9 routing
    wr(4'h2, 8'h40);
    pin(1, 1'b1, "R9"); pin(2, 1'b0, "R9"); rd(4'h2, 8'h40, "R9");
    wr(4'h5, 8'h01);
    pin(2, 1'b1, "R9"); rd(4'h5, 8'h01, "R9");
    wr(4'h1, 8'h01);
    pin(2, 1'b0, "R9"); rd(4'h1, 8'h00, "R8"); pin(1, 1'b1, "R9");
    wr(4'h0, 8'h40);
    pin(1, 1'b0, "R9"); rd(4'h0, 8'h00, "R8");

    // R8 set wins over same-cycle clear
    wr_smp(4'h0, 8'h40, 2'd2, 8'h20);
    rd(4'h0, 8'h40, "R8"); pin(1, 1'b1, "R9");
    wr(4'h0, 8'h40); rd(4'h0, 8'h00, "R8");

    // R10 out-of-range selector, 4 aliases channel 0 in its low bits
    wr(4'h9, 8'h04);
    rd(4'h9, 8'h04, "R10"); rd(4'hA, 8'h00, "R10"); rd(4'hB, 8'h00, "R10");
    rd(4'hC, 8'h00, "R10"); rd(4'hD, 8'h00, "R10"); rd(4'hE, 8'h00, "R10");
    wr(4'hC, 8'h77); wr(4'hA, 8'h00);
    wr(4'h9, 8'h00);
    rd(4'hC, 8'h35, "R10"); rd(4'hA, 8'h01, "R10");
    wr(4'h9, 8'h01); rd(4'hC, 8'h35, "R10");

    // R12 reading is read-only
    wr(4'h9, 8'h00); wr(4'hB, 8'h99);
    rd(4'hB, 8'h04, "R12");

    // R11 config byte and unmapped offsets
    wr(4'h8, 8'hA5); rd(4'h8, 8'hA5, "R11");
    rd(4'h6, 8'h00, "R11");
    wr(4'h7, 8'h3C); rd(4'h7, 8'h00, "R11"); rd(4'hF, 8'h00, "R11");
    pin(1, 1'b0, "R9"); pin(2, 1'b0, "R9");

    wait (sbq.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule